// File: doc/BRIEF.md
# Triggered Sample Window Capture

This block sits behind an ADC sample stream and keeps the most recent samples in an on-chip ring memory. Once it is armed, every valid sample is stored. When an event is detected, it keeps storing until a programmed number of after-event samples has arrived. It then stops storing and streams the event's window out through a valid/ready port: the programmed number of before-event samples, followed by the after-event samples, oldest first. A DMA-style consumer can take each window as soon as it is complete, so the full-rate data is reduced to the region around each event.

The event source is chosen at run time. It is either an external pulse sampled together with a valid sample, or a level detector that fires when a sample exceeds a programmed threshold. A small write-only register port sets the arm bit, the source, the two lengths and the threshold. The current phase and a flag for a short history are driven on dedicated outputs.

Top module: `trig_window_capture`

## Requirements
- R1: During and after reset, `cap_state` is 0, `m_valid` is low and `pre_short` is low.
- R2: `cap_state` encodes idle=0, armed=1, post-event collection=2, draining=3. The phase moves from idle to armed on the cycle after the arm bit is seen set. Clearing the arm bit while armed returns to idle, and no event is accepted while idle.
- R3: With the source bit at 0, a valid sample that arrives together with a high `ext_trig` while armed is the event sample, and it is the first after-event sample.
- R4: With the source bit at 1, a valid sample whose unsigned value is strictly greater than the threshold is the event sample. A sample equal to the threshold does not trigger.
- R5: A window holds min(pre length, samples stored since arming) samples that precede the event, then the event sample and the following samples, in arrival order. The after-event count is the post length, and a post length of 0 counts as 1. Software keeps pre + post no larger than the memory depth.
- R6: `pre_short` is updated at each event. It is set when fewer samples were stored since arming than the pre length asks for, and cleared otherwise.
- R7: During post-event collection and draining, event inputs are ignored. Samples that arrive while draining are not stored and do not appear in any window.
- R8: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` stay unchanged. `m_last` is high on exactly the final sample of each window.
- R9: After the final sample of a window is accepted, the phase returns to armed if the arm bit is still set, otherwise to idle. The count of stored history restarts from zero.
- R10: Register writes take effect on the next cycle. Address 0 holds control (bit 0 arm, bit 1 source), address 1 the pre length, address 2 the post length and address 3 the threshold. Lengths and threshold are captured when the event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value, unsigned |
| ext_trig | input | 1 | External event input, sampled with smp_valid |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Consumer ready |
| m_data | output | DATA_W | Output sample |
| m_last | output | 1 | Final sample of a window |
| cap_state | output | 2 | Current phase |
| pre_short | output | 1 | Last event had less history than requested |

## Verification
A wrong read pointer or a wrong stored-history count does not show as a bad phase. It shows as shifted or stale values in `m_data` on the first beat of the next window, a few cycles after the event completes, so every accepted beat is compared with the sample expected at that position. A miscounted window length shows as `m_last` landing on the wrong beat, or as the phase staying in draining or leaving it early, and this is visible on `cap_state` in the cycle the final beat is accepted. Event acceptance errors show on `cap_state` within one cycle of the offending sample.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DRAIN = 2'd3
  } cap_state_t;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_PRE    = 2'd1;
  localparam logic [1:0] REG_POST   = 2'd2;
  localparam logic [1:0] REG_THRESH = 2'd3;
endpackage

// File: rtl/cap_cfg_regs.sv
module cap_cfg_regs
  import trig_cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              arm,
  output logic              src_lvl,
  output logic [CNT_W-1:0]  pre_len,
  output logic [CNT_W-1:0]  post_len,
  output logic [DATA_W-1:0] thresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      arm      <= 1'b0;
      src_lvl  <= 1'b0;
      pre_len  <= '0;
      post_len <= '0;
      thresh   <= '0;
    end else if (wr) begin
      case (addr)
        REG_CTRL: begin
          arm     <= wdata[0];
          src_lvl <= wdata[1];
        end
        REG_PRE:  pre_len  <= wdata[CNT_W-1:0];
        REG_POST: post_len <= wdata[CNT_W-1:0];
        default:  thresh   <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/cap_sample_ring.sv
module cap_sample_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cap_window_ctrl.sv
module cap_window_ctrl
  import trig_cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              ext_trig,
  input  logic              arm,
  input  logic              src_lvl,
  input  logic [CNT_W-1:0]  pre_len,
  input  logic [CNT_W-1:0]  post_len,
  input  logic [DATA_W-1:0] thresh,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              m_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output cap_state_t        state,
  output logic              short_flag
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill, post_left, rd_left, pre_eff, post_eff;
  logic              pend, pend_last, hit, accept, issue, done;

  assign hit      = src_lvl ? (smp_data > thresh) : ext_trig;
  assign accept   = (state == ST_ARMED) && arm && smp_valid && hit;
  assign wr_en    = smp_valid && ((state == ST_ARMED) || (state == ST_POST));
  assign wr_addr  = wr_ptr;
  assign rd_addr  = rd_ptr;
  assign pre_eff  = (pre_len < fill) ? pre_len : fill;
  assign post_eff = (post_len == '0) ? ONE : post_len;
  assign issue    = (state == ST_DRAIN) && (rd_left != '0) && !pend && (!m_valid || m_ready);
  assign done     = m_valid && m_ready && m_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill       <= '0;
      post_left  <= '0;
      rd_left    <= '0;
      short_flag <= 1'b0;
      pend       <= 1'b0;
      pend_last  <= 1'b0;
      m_valid    <= 1'b0;
      m_data     <= '0;
      m_last     <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;

      case (state)
        ST_IDLE: begin
          if (arm) begin
            state <= ST_ARMED;
            fill  <= '0;
          end
        end
        ST_ARMED: begin
          if (!arm) begin
            state <= ST_IDLE;
          end else if (accept) begin
            rd_ptr     <= wr_ptr - pre_eff[ADDR_W-1:0];
            rd_left    <= pre_eff + post_eff;
            post_left  <= post_eff - ONE;
            short_flag <= (pre_len > fill);
            state      <= (post_eff == ONE) ? ST_DRAIN : ST_POST;
          end else if (smp_valid && (fill != FULL)) begin
            fill <= fill + ONE;
          end
        end
        ST_POST: begin
          if (smp_valid) begin
            post_left <= post_left - ONE;
            if (post_left == ONE) state <= ST_DRAIN;
          end
        end
        default: begin
          if (done) begin
            state <= arm ? ST_ARMED : ST_IDLE;
            fill  <= '0;
          end
        end
      endcase

      // Read side: one memory read in flight, loaded into the output register next cycle
      pend <= issue;
      if (issue) begin
        rd_ptr    <= rd_ptr + 1'b1;
        rd_left   <= rd_left - ONE;
        pend_last <= (rd_left == ONE);
      end
      if (pend) begin
        m_valid <= 1'b1;
        m_data  <= rd_data;
        m_last  <= pend_last;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trig_window_capture.sv
module trig_window_capture
  import trig_cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              ext_trig,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic [1:0]        cap_state,
  output logic              pre_short
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;

  logic              arm, src_lvl;
  logic [CNT_W-1:0]  pre_len, post_len;
  logic [DATA_W-1:0] thresh, rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  cap_state_t        state;

  cap_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .arm(arm), .src_lvl(src_lvl), .pre_len(pre_len), .post_len(post_len),
    .thresh(thresh)
  );

  cap_sample_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(smp_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cap_window_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .ext_trig(ext_trig), .arm(arm), .src_lvl(src_lvl), .pre_len(pre_len),
    .post_len(post_len), .thresh(thresh), .rd_data(rd_data), .m_ready(m_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .m_valid(m_valid),
    .m_data(m_data), .m_last(m_last), .state(state), .short_flag(pre_short)
  );

  assign cap_state = state;
endmodule

// File: rtl/trig_window_capture_chk.sv
module trig_window_capture_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input logic [1:0]        cap_state,
  input logic              pre_short
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R2
  valid_only_drain_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (cap_state == 2'd3));

  // R7
  post_goes_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_state == 2'd2) |=> (cap_state == 2'd2 || cap_state == 2'd3));

  // R9
  drain_until_last_chk: assert property (@(posedge clk) disable iff (rst)
    ((cap_state == 2'd3) && !(m_valid && m_ready && m_last)) |=> (cap_state == 2'd3));

  // R2
  idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_state == 2'd0) |=> (cap_state == 2'd0 || cap_state == 2'd1));

  // R6
  short_at_event_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pre_short) |-> ($past(cap_state) == 2'd1));
endmodule

bind trig_window_capture trig_window_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_last(m_last), .cap_state(cap_state), .pre_short(pre_short)
);

// File: tb/test_trig_window_capture.sv
module test_trig_window_capture;
  localparam int DW = 16;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic smp_valid = 1'b0, ext_trig = 1'b0, cfg_wr = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] smp_data = '0, cfg_wdata = '0;
  logic [1:0] cfg_addr = '0;
  logic m_valid, m_last, pre_short;
  logic [DW-1:0] m_data;
  logic [1:0] cap_state;

  trig_window_capture #(.DATA_W(DW), .DEPTH(DEPTH)) i_trig_window_capture (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .ext_trig(ext_trig), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .cap_state(cap_state), .pre_short(pre_short)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, windows = 0, seq = 0;
  bit finished = 0;
  // reference model
  int ms = 0, pre_r = 0, post_r = 0, thr_r = 0, post_left = 0;
  bit arm_r = 0, src_r = 0, short_m = 0, held = 0;
  int held_data = 0, held_last = 0;
  int hist[$];
  int expq[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, int d, bit et, bit wr, int a, int wd, bit rdy);
    bit hs, lastm, hit;
    int e, pe, pst;
    smp_valid = v; smp_data = DW'(d); ext_trig = et;
    cfg_wr = wr; cfg_addr = 2'(a); cfg_wdata = DW'(wd); m_ready = rdy;
    // compare outputs against model
    chk(int'(cap_state) == ms, "R2/R9 state", int'(cap_state), ms);
    chk(pre_short == short_m, "R6 short flag", int'(pre_short), int'(short_m));
    if (held) begin
      chk(m_valid && int'(m_data) == held_data && int'(m_last) == held_last,
          "R8 hold", int'(m_data), held_data);
    end
    if (m_valid) chk(ms == 3 && expq.size() > 0, "R8 valid outside window", ms, 3);
    hs = m_valid && rdy;
    lastm = 0;
    if (hs && expq.size() > 0) begin
      e = expq.pop_front();
      chk(int'(m_data) == e, "R5 window data", int'(m_data), e);
      chk(int'(m_last) == int'(expq.size() == 0), "R8 last marker", int'(m_last),
          int'(expq.size() == 0));
      lastm = (expq.size() == 0);
    end
    held = m_valid && !rdy;
    held_data = int'(m_data); held_last = int'(m_last);
    // advance model to the next edge
    hit = src_r ? (d > thr_r) : et;
    case (ms)
      0: if (arm_r) begin ms = 1; hist.delete(); end
      1: if (!arm_r) ms = 0;
         else if (v && hit) begin
           pe = (pre_r < hist.size()) ? pre_r : hist.size();
           short_m = (pre_r > hist.size());
           expq.delete();
           for (int i = hist.size() - pe; i < hist.size(); i++) expq.push_back(hist[i]);
           expq.push_back(d);
           pst = (post_r == 0) ? 1 : post_r;
           post_left = pst - 1;
           ms = (post_left == 0) ? 3 : 2;
         end else if (v) begin
           hist.push_back(d);
           if (hist.size() > DEPTH) void'(hist.pop_front());
         end
      2: if (v) begin
           expq.push_back(d);
           post_left--;
           if (post_left == 0) ms = 3;
         end
      default: if (lastm) begin
           windows++;
           ms = arm_r ? 1 : 0;
           hist.delete();
         end
    endcase
    if (wr) begin
      case (a)
        0: begin arm_r = wd[0]; src_r = wd[1]; end
        1: pre_r = wd & 127;
        2: post_r = wd & 127;
        default: thr_r = wd & 16'hFFFF;
      endcase
    end
    cycles++;
    @(negedge clk);
  endtask

  task automatic wr_reg(int a, int wd);
    cyc(0, 0, 0, 1, a, wd, 1);
  endtask

  // free-running traffic; pv = valid percent, pt = ext event percent, pr = ready percent
  task automatic traffic(int n, int pv, int pt, int pr);
    for (int i = 0; i < n; i++) begin
      seq++;
      cyc(($urandom % 100) < pv, seq % 900, ($urandom % 100) < pt, 0, 0, 0,
          ($urandom % 100) < pr);
    end
  endtask

  task automatic drain_out(int pr);
    for (int i = 0; i < 2000 && (ms == 2 || ms == 3); i++) begin
      seq++;
      cyc(1, seq % 900, ($urandom % 100) < 30, 0, 0, 0, ($urandom % 100) < pr);
    end
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset held
    chk(cap_state == 2'd0 && !m_valid && !pre_short, "R1 reset", int'(cap_state), 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk(cap_state == 2'd0 && !m_valid, "R1 after reset", int'(cap_state), 0);

    // R2: event while idle ignored
    cyc(1, 5, 1, 0, 0, 0, 1);
    cyc(1, 6, 1, 0, 0, 0, 1);
    chk(cap_state == 2'd0, "R2 idle ignores event", int'(cap_state), 0);

    // R10: pre=5 post=4, external source, arm
    wr_reg(1, 5); wr_reg(2, 4); wr_reg(0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk(cap_state == 2'd1, "R2 armed", int'(cap_state), 1);
    traffic(20, 100, 0, 100);
    seq++; cyc(1, seq % 900, 1, 0, 0, 0, 1);
    chk(cap_state == 2'd2, "R3 external event", int'(cap_state), 2);
    traffic(2, 100, 100, 100);
    chk(cap_state == 2'd2, "R7 events ignored in post", int'(cap_state), 2);
    drain_out(40);
    chk(windows == 1, "R9 one window done", windows, 1);
    chk(cap_state == 2'd1, "R9 back to armed", int'(cap_state), 1);

    // R6: event after only two stored samples
    traffic(2, 100, 0, 100);
    seq++; cyc(1, seq % 900, 1, 0, 0, 0, 1);
    chk(pre_short == 1'b1, "R6 short set", int'(pre_short), 1);
    drain_out(60);

    // R5: pre 0 / post 0 -> single sample window
    wr_reg(1, 0); wr_reg(2, 0);
    traffic(6, 100, 0, 100);
    w0 = windows;
    seq++; cyc(1, seq % 900, 1, 0, 0, 0, 1);
    chk(cap_state == 2'd3, "R5 post zero acts as one", int'(cap_state), 3);
    chk(pre_short == 1'b0, "R6 short clear", int'(pre_short), 0);
    drain_out(100);
    chk(windows == w0 + 1, "R5 single window", windows, w0 + 1);

    // R4: level source, threshold 1000
    wr_reg(3, 1000); wr_reg(1, 3); wr_reg(2, 3); wr_reg(0, 3);
    traffic(10, 80, 50, 100);
    chk(cap_state == 2'd1, "R4 below threshold no event", int'(cap_state), 1);
    cyc(1, 1000, 0, 0, 0, 0, 1);
    chk(cap_state == 2'd1, "R4 equal does not trigger", int'(cap_state), 1);
    cyc(1, 1001, 0, 0, 0, 0, 1);
    chk(cap_state == 2'd2, "R4 above triggers", int'(cap_state), 2);
    drain_out(30);

    // R2: disarm while armed, then events ignored
    wr_reg(0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk(cap_state == 2'd0, "R2 disarm", int'(cap_state), 0);
    cyc(1, 2000, 1, 0, 0, 0, 1);
    chk(cap_state == 2'd0, "R2 no event when disarmed", int'(cap_state), 0);

    // R5/R8: full-depth window with heavy backpressure, external source
    wr_reg(1, 40); wr_reg(2, 24); wr_reg(0, 1);
    traffic(120, 70, 0, 100);
    seq++; cyc(1, seq % 900, 1, 0, 0, 0, 1);
    drain_out(25);
    chk(cap_state == 2'd1, "R9 armed after big window", int'(cap_state), 1);

    // R7: windows while arm dropped during drain -> idle afterwards
    wr_reg(1, 4); wr_reg(2, 2);
    traffic(10, 100, 0, 100);
    seq++; cyc(1, seq % 900, 1, 0, 0, 0, 0);
    cyc(1, 7, 0, 0, 0, 0, 0);
    wr_reg(0, 0);
    traffic(4, 100, 100, 0);
    chk(cap_state == 2'd3, "R7 events ignored in drain", int'(cap_state), 3);
    drain_out(50);
    chk(cap_state == 2'd0, "R9 idle after disarm", int'(cap_state), 0);

    // random mixed traffic
    wr_reg(0, 1);
    for (int k = 0; k < 6; k++) begin
      traffic(60, 60, 5, 50);
      drain_out(50);
    end
    drain_out(50);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule